// File: doc/BRIEF.md
# Power-of-two block allocator with split and coalesce

This block hands out and takes back regions of a fixed pool of memory units. Every region it manages is a power-of-two number of units, aligned to its own size. An allocation request carries a size in units. The block rounds that size up to a power of two and looks for a free region of that order or larger. If the region it finds is larger than needed, it cuts the region in half, and keeps cutting, until a piece of the requested order remains. The halves it does not hand out go back onto the free set of their order. The response returns the base address and the order that was granted.

A release request carries the base address and the order that was granted. The block marks the region free. It then checks whether the partner region of the same order, at base XOR size, is also free. If it is, the two are joined into one region of the next order up, and this repeats until the partner is not free or the whole pool has been rebuilt. Free state is held as one bit per possible region, arranged by order.

Requests and responses use valid/ready handshakes. Only one request is handled at a time. The request side stays closed while a split or join sequence is running, and until the response has been taken.

Top module: `buddy_alloc`

## Requirements
- R1: After reset the whole pool of 2^ORD_MAX units (256 by default) is one free region of order ORD_MAX. req_ready is 1 and rsp_valid is 0.
- R2: An allocation of size s is granted at order ceil(log2(s)), and a size of 0 is treated as 1. rsp_order carries the granted order.
- R3: An allocation takes the smallest order at or above the needed order that has any free region, and within that order the lowest address. rsp_addr is the base of the granted block in units.
- R4: When the chosen region's order f is above the needed order n, the upper half at each order from f-1 down to n becomes free. rsp_valid rises (f-n)+1 cycles after the accepting clock edge.
- R5: A size greater than the pool, or an allocation with no free region at any sufficient order, responds with rsp_ok=0 and rsp_err=0 one cycle after acceptance, and leaves the free state unchanged.
- R6: A release of a region (addr, k) merges it with its free partner at addr XOR 2^k, repeatedly, up to order ORD_MAX. The response has rsp_ok=1 and reports the base and order of the final merged region. After m merges, rsp_valid rises m+2 cycles after acceptance.
- R7: A release is refused with rsp_err=1 and rsp_ok=0, one cycle after acceptance, and changes nothing, in any of these cases: the region, or a region of higher order that contains it, is already free; the order is above ORD_MAX; or the address is not a multiple of 2^k.
- R8: req_op=0 selects allocation and req_op=1 selects release. req_ready is 0 from the cycle after acceptance until the response has been taken with rsp_ready. While rsp_ready is 0, the response fields stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_size | input | ORD_MAX+1 | Allocation size in units |
| req_addr | input | ORD_MAX | Release base address in units |
| req_order | input | ORD_W | Release order as originally granted |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_ok | output | 1 | Request carried out |
| rsp_err | output | 1 | Release refused |
| rsp_addr | output | ORD_MAX | Granted or merged base address |
| rsp_order | output | ORD_W | Granted or merged order |

## Verification
The checks assume that the requester holds its request fields steady while req_valid is high, and that it releases only blocks it was granted, or exact repeats of such blocks. A release of a larger region while a smaller piece inside it is free is not detected. The stimulus therefore picks every release from a list of live grants, and builds its double releases from blocks that were just returned. The partner-join checks assume that the free bits never hold a region and its partner as free at the same time. That property comes from the merge rule applied to those legal sequences.

// File: rtl/bdy_pkg.sv
package bdy_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_MERGE,
    ST_RESP
  } bdy_state_t;

  localparam logic OP_ALLOC = 1'b0;
  localparam logic OP_FREE  = 1'b1;

  // smallest k with 2^k >= size; size 0 maps to 0
  function automatic int ceil_order(input int size);
    int o;
    o = 0;
    for (int k = 31; k >= 0; k--) begin
      if ((64'd1 << k) >= 64'(size)) o = k;
    end
    return o;
  endfunction

  // first bit of the free row for order k when the top order is m
  function automatic int map_base(input int k, input int m);
    return (1 << (m + 1)) - (1 << (m + 1 - k));
  endfunction

  // bits below the alignment of a region of order o
  function automatic int low_mask(input int o);
    return (1 << o) - 1;
  endfunction

endpackage

// File: rtl/bdy_map.sv
module bdy_map
  import bdy_pkg::*;
#(
  parameter int ORD_MAX = 8,
  parameter int ORD_W   = 4,
  localparam int AW = ORD_MAX,
  localparam int NB = (1 << (ORD_MAX + 1)) - 1,
  localparam int IW = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [ORD_W-1:0] clr_ord,
  input  logic [AW-1:0]    clr_addr,
  input  logic             set_en,
  input  logic [ORD_W-1:0] set_ord,
  input  logic [AW-1:0]    set_addr,
  output logic [NB-1:0]    map_q
);

  function automatic logic [IW-1:0] slot(input logic [ORD_W-1:0] o, input logic [AW-1:0] a);
    return IW'(map_base(int'(o), ORD_MAX) + int'(a >> o));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q <= NB'(1) << map_base(ORD_MAX, ORD_MAX);
    end else begin
      if (clr_en) map_q[slot(clr_ord, clr_addr)] <= 1'b0;
      if (set_en) map_q[slot(set_ord, set_addr)] <= 1'b1;
    end
  end

endmodule

// File: rtl/bdy_search.sv
module bdy_search
  import bdy_pkg::*;
#(
  parameter int ORD_MAX = 8,
  parameter int ORD_W   = 4,
  localparam int AW = ORD_MAX,
  localparam int NB = (1 << (ORD_MAX + 1)) - 1,
  localparam int IW = $clog2(NB)
) (
  input  logic [NB-1:0]    map_q,
  input  logic [ORD_W-1:0] need_ord,
  input  logic [ORD_W-1:0] look_ord,
  input  logic [AW-1:0]    look_addr,
  output logic             found,
  output logic [ORD_W-1:0] f_ord,
  output logic [AW-1:0]    f_addr,
  output logic             look_exact,
  output logic             look_cover
);

  localparam logic [ORD_MAX:0] ONE = {{ORD_MAX{1'b0}}, 1'b1};

  logic [ORD_MAX:0]          hit;
  logic [ORD_MAX:0]          look_row;
  logic [(ORD_MAX+1)*AW-1:0] lo_flat;

  for (genvar k = 0; k <= ORD_MAX; k++) begin : g_ord
    localparam int CNT  = 1 << (ORD_MAX - k);
    localparam int BASE = map_base(k, ORD_MAX);
    logic [CNT-1:0] row;
    logic [AW-1:0]  lo;
    assign row = map_q[BASE +: CNT];
    assign hit[k] = |row;
    always_comb begin
      lo = '0;
      for (int i = CNT - 1; i >= 0; i--) begin
        if (row[i]) lo = AW'(i << k);
      end
    end
    assign lo_flat[k*AW +: AW] = lo;
    assign look_row[k] = map_q[IW'(BASE + int'(look_addr >> k))];
  end

  logic [ORD_MAX:0] need_sel, need_ge, look_sel, look_ge;
  assign need_sel = ONE << need_ord;
  assign need_ge  = ~(need_sel - ONE);
  assign look_sel = ONE << look_ord;
  assign look_ge  = ~(look_sel - ONE);

  assign look_exact = |(look_row & look_sel);
  assign look_cover = |(look_row & look_ge);

  always_comb begin
    found  = 1'b0;
    f_ord  = '0;
    f_addr = '0;
    for (int k = ORD_MAX; k >= 0; k--) begin
      if (hit[k] && need_ge[k]) begin
        found  = 1'b1;
        f_ord  = ORD_W'(k);
        f_addr = lo_flat[k*AW +: AW];
      end
    end
  end

endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
  import bdy_pkg::*;
#(
  parameter int ORD_MAX = 8,
  localparam int ORD_W = $clog2(ORD_MAX + 2),
  localparam int AW = ORD_MAX,
  localparam int SW = ORD_MAX + 1,
  localparam int NB = (1 << (ORD_MAX + 1)) - 1,
  localparam int POOL = 1 << ORD_MAX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic [SW-1:0]    req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [ORD_W-1:0] req_order,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_ok,
  output logic             rsp_err,
  output logic [AW-1:0]    rsp_addr,
  output logic [ORD_W-1:0] rsp_order
);

  bdy_state_t       state;
  logic [ORD_W-1:0] cur_ord, tgt_ord;
  logic [AW-1:0]    cur_addr;
  logic [NB-1:0]    map_q;

  logic             found, look_exact, look_cover;
  logic [ORD_W-1:0] f_ord, need_ord, look_ord;
  logic [AW-1:0]    f_addr, look_addr, buddy_addr;

  logic             clr_en, set_en;
  logic [ORD_W-1:0] clr_ord, set_ord;
  logic [AW-1:0]    clr_addr, set_addr;

  // named events for the checker
  logic acc_evt, acc_alloc, acc_free, alloc_ok, free_bad;
  logic split_evt, merge_evt, settle_evt;
  logic [ORD_W-1:0] dn_ord;

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);

  assign need_ord   = ORD_W'(ceil_order(int'(req_size)));
  assign buddy_addr = cur_addr ^ (AW'(1) << cur_ord);
  assign dn_ord     = cur_ord - ORD_W'(1);
  assign look_ord   = (state == ST_MERGE) ? cur_ord : req_order;
  assign look_addr  = (state == ST_MERGE) ? buddy_addr : req_addr;

  assign acc_evt   = req_valid && req_ready;
  assign acc_alloc = acc_evt && (req_op == OP_ALLOC);
  assign acc_free  = acc_evt && (req_op == OP_FREE);
  assign alloc_ok  = found && (int'(req_size) <= POOL);
  assign free_bad  = (req_order > ORD_W'(ORD_MAX)) || look_cover ||
                     ((req_addr & AW'(low_mask(int'(req_order)))) != '0);

  assign split_evt  = (state == ST_SPLIT);
  assign merge_evt  = (state == ST_MERGE) && (cur_ord < ORD_W'(ORD_MAX)) && look_exact;
  assign settle_evt = (state == ST_MERGE) && !merge_evt;

  bdy_search #(.ORD_MAX(ORD_MAX), .ORD_W(ORD_W)) u_search (
    .map_q      (map_q),
    .need_ord   (need_ord),
    .look_ord   (look_ord),
    .look_addr  (look_addr),
    .found      (found),
    .f_ord      (f_ord),
    .f_addr     (f_addr),
    .look_exact (look_exact),
    .look_cover (look_cover)
  );

  always_comb begin
    clr_en = 1'b0; clr_ord = '0; clr_addr = '0;
    set_en = 1'b0; set_ord = '0; set_addr = '0;
    if (acc_alloc && alloc_ok) begin
      clr_en = 1'b1; clr_ord = f_ord; clr_addr = f_addr;
    end
    if (split_evt) begin
      set_en = 1'b1; set_ord = dn_ord;
      set_addr = cur_addr | (AW'(1) << dn_ord);
    end
    if (merge_evt) begin
      clr_en = 1'b1; clr_ord = cur_ord; clr_addr = buddy_addr;
    end
    if (settle_evt) begin
      set_en = 1'b1; set_ord = cur_ord; set_addr = cur_addr;
    end
  end

  bdy_map #(.ORD_MAX(ORD_MAX), .ORD_W(ORD_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (clr_en),
    .clr_ord  (clr_ord),
    .clr_addr (clr_addr),
    .set_en   (set_en),
    .set_ord  (set_ord),
    .set_addr (set_addr),
    .map_q    (map_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_ord   <= '0;
      cur_addr  <= '0;
      tgt_ord   <= '0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
      rsp_order <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (acc_alloc) begin
            if (alloc_ok) begin
              cur_ord  <= f_ord;
              cur_addr <= f_addr;
              tgt_ord  <= need_ord;
              if (f_ord == need_ord) begin
                rsp_ok <= 1'b1; rsp_err <= 1'b0;
                rsp_addr <= f_addr; rsp_order <= f_ord;
                state <= ST_RESP;
              end else begin
                state <= ST_SPLIT;
              end
            end else begin
              rsp_ok <= 1'b0; rsp_err <= 1'b0;
              rsp_addr <= '0; rsp_order <= '0;
              state <= ST_RESP;
            end
          end else if (acc_free) begin
            if (free_bad) begin
              rsp_ok <= 1'b0; rsp_err <= 1'b1;
              rsp_addr <= req_addr; rsp_order <= req_order;
              state <= ST_RESP;
            end else begin
              cur_ord  <= req_order;
              cur_addr <= req_addr;
              state    <= ST_MERGE;
            end
          end
        end
        ST_SPLIT: begin
          cur_ord <= dn_ord;
          if (dn_ord == tgt_ord) begin
            rsp_ok <= 1'b1; rsp_err <= 1'b0;
            rsp_addr <= cur_addr; rsp_order <= dn_ord;
            state <= ST_RESP;
          end
        end
        ST_MERGE: begin
          if (merge_evt) begin
            cur_addr <= cur_addr & ~(AW'(1) << cur_ord);
            cur_ord  <= cur_ord + ORD_W'(1);
          end else begin
            rsp_ok <= 1'b1; rsp_err <= 1'b0;
            rsp_addr <= cur_addr; rsp_order <= cur_ord;
            state <= ST_RESP;
          end
        end
        default: begin
          if (rsp_ready) state <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/bdy_alloc_chk.sv
module bdy_alloc_chk
  import bdy_pkg::*;
#(
  parameter int ORD_MAX = 8,
  parameter int ORD_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_ok,
  input logic               rsp_err,
  input logic [ORD_MAX-1:0] rsp_addr,
  input logic [ORD_W-1:0]   rsp_order,
  input logic               split_evt,
  input logic               merge_evt,
  input logic [ORD_W-1:0]   cur_ord,
  input logic [ORD_W-1:0]   tgt_ord
);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_rsp_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r8_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ok) && $stable(rsp_err)
                                   && $stable(rsp_addr) && $stable(rsp_order)));

  a_r7_err_excludes_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !rsp_ok);

  a_r3_grant_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok) |->
      (rsp_order <= ORD_W'(ORD_MAX)) &&
      ((rsp_addr & ORD_MAX'(low_mask(int'(rsp_order)))) == '0));

  a_r4_split_above_target: assert property (@(posedge clk) disable iff (!rst_n)
    split_evt |-> (cur_ord > tgt_ord));

  a_r6_merge_below_top: assert property (@(posedge clk) disable iff (!rst_n)
    merge_evt |-> (cur_ord < ORD_W'(ORD_MAX)));

endmodule

bind buddy_alloc bdy_alloc_chk #(.ORD_MAX(ORD_MAX), .ORD_W(ORD_W)) u_chk (.*);

// File: tb/sim_buddy_alloc.sv
module sim_buddy_alloc;

  localparam int M  = 8;
  localparam int OW = 4;
  localparam int P  = 1 << M;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0, rsp_ready = 1'b1;
  logic [M:0] req_size = '0;
  logic [M-1:0] req_addr = '0;
  logic [OW-1:0] req_order = '0;
  logic req_ready, rsp_valid, rsp_ok, rsp_err;
  logic [M-1:0] rsp_addr;
  logic [OW-1:0] rsp_order;

  always #5 clk = ~clk;

  buddy_alloc #(.ORD_MAX(M)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_addr(req_addr), .req_order(req_order),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
    .rsp_addr(rsp_addr), .rsp_order(rsp_order)
  );

  int n_chk = 0, n_bad = 0;
  bit rf [0:M][0:P-1];
  int al_a [0:P-1];
  int al_o [0:P-1];
  int al_n = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int need_of(input int s);
    int o = 0;
    while ((1 << o) < s) o++;
    return o;
  endfunction

  // drive one request; returns the response fields and the latency
  task automatic do_op(input logic op, input int size, input int a, input int o, input int hold,
                       output int ok, output int err, output int ra, output int ro, output int lat);
    @(negedge clk);
    if (hold > 0) rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = op; req_size = (M+1)'(size);
    req_addr = M'(a); req_order = OW'(o);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    ok = int'(rsp_ok); err = int'(rsp_err); ra = int'(rsp_addr); ro = int'(rsp_order);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check("R8 held rsp_valid", int'(rsp_valid), 1);
      check("R8 held req_ready", int'(req_ready), 0);
      check("R8 held rsp_addr", int'(rsp_addr), ra);
      check("R8 held rsp_order", int'(rsp_order), ro);
      rsp_ready = 1'b1;
    end
  endtask

  task automatic alloc_chk(input int size, input int hold, output int ok, output int ga, output int go);
    int need, fk, fi, eok, elat, err, lat;
    need = need_of(size); eok = 0; fk = 0; fi = 0;
    if (size <= P) begin
      for (int k = need; k <= M; k++)
        for (int i = 0; i < (P >> k); i++)
          if (rf[k][i] && eok == 0) begin eok = 1; fk = k; fi = i; end
    end
    elat = 1;
    if (eok != 0) begin
      rf[fk][fi] = 1'b0;
      for (int j = fk - 1; j >= need; j--) rf[j][((fi << fk) >> j) + 1] = 1'b1;
      elat = fk - need + 1;
    end
    do_op(1'b0, size, 0, 0, hold, ok, err, ga, go, lat);
    check(eok != 0 ? "R3 alloc ok" : "R5 alloc fail", ok, eok);
    check("R5 alloc no err", err, 0);
    if (eok != 0) begin
      check("R3 alloc addr", ga, fi << fk);
      check("R2 alloc order", go, need);
      check("R4 alloc latency", lat, elat);
    end else begin
      check("R5 fail latency", lat, 1);
    end
  endtask

  task automatic free_chk(input int a, input int o);
    int eerr, ma, mo, m, ok, err, ra, ro, lat;
    eerr = 0;
    if (o > M) eerr = 1;
    else if ((a & ((1 << o) - 1)) != 0) eerr = 1;
    else for (int j = o; j <= M; j++) if (rf[j][a >> j]) eerr = 1;
    do_op(1'b1, 0, a, o, 0, ok, err, ra, ro, lat);
    check("R7 free err flag", err, eerr);
    check("R6 free ok", ok, 1 - eerr);
    if (eerr != 0) begin
      check("R7 refused latency", lat, 1);
    end else begin
      ma = a; mo = o; m = 0;
      while (mo < M && rf[mo][(ma >> mo) ^ 1]) begin
        rf[mo][(ma >> mo) ^ 1] = 1'b0;
        ma = ma & ~(1 << mo); mo++; m++;
      end
      rf[mo][ma >> mo] = 1'b1;
      check("R6 merged addr", ra, ma);
      check("R6 merged order", ro, mo);
      check("R6 merge latency", lat, m + 2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ok, ga, go;
    logic [15:0] lfsr;
    for (int k = 0; k <= M; k++) for (int i = 0; i < P; i++) rf[k][i] = 1'b0;
    rf[M][0] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset req_ready", int'(req_ready), 1);
    check("R1 reset rsp_valid", int'(rsp_valid), 0);

    // R1: the whole pool is one block
    alloc_chk(P, 0, ok, ga, go);
    free_chk(0, M);

    // R2 R3 R4: every size from an empty pool
    for (int s = 0; s <= P; s++) begin
      alloc_chk(s, 0, ok, ga, go);
      if (ok != 0) free_chk(ga, go);
    end

    // R5: oversize leaves state alone
    alloc_chk(P + 1, 0, ok, ga, go);
    alloc_chk(2 * P - 1, 0, ok, ga, go);
    alloc_chk(P, 0, ok, ga, go);
    free_chk(0, M);

    // fill with unit blocks, lowest address first
    for (int i = 0; i < P; i++) alloc_chk(1, 0, ok, ga, go);
    alloc_chk(1, 0, ok, ga, go);
    free_chk(3, 9);
    free_chk(2, 1);
    for (int i = 0; i < P; i += 2) free_chk(i, 0);
    free_chk(0, 0);
    for (int i = 1; i < P; i += 2) free_chk(i, 0);
    free_chk(4, 2);
    free_chk(0, M);

    // R8: response held under backpressure
    alloc_chk(5, 4, ok, ga, go);
    free_chk(ga, go);

    // mixed traffic against the model
    lfsr = 16'hACE1;
    for (int step = 0; step < 1500; step++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (al_n > 0 && (lfsr[0] || al_n > 200)) begin
        int idx;
        idx = int'(lfsr[15:8]) % al_n;
        free_chk(al_a[idx], al_o[idx]);
        if (lfsr[5] && lfsr[6]) free_chk(al_a[idx], al_o[idx]);
        al_n--;
        al_a[idx] = al_a[al_n]; al_o[idx] = al_o[al_n];
      end else begin
        int sz;
        case (lfsr[2:1])
          2'd0: sz = 1 + int'(lfsr[11:3] & 9'd1);
          2'd1: sz = 1 + int'(lfsr[11:3] & 9'd7);
          2'd2: sz = 1 + int'(lfsr[11:3] & 9'd31);
          default: sz = 1 + int'(lfsr[11:3] & 9'd255);
        endcase
        alloc_chk(sz, 0, ok, ga, go);
        if (ok != 0) begin al_a[al_n] = ga; al_o[al_n] = go; al_n++; end
      end
    end
    while (al_n > 0) begin
      al_n--;
      free_chk(al_a[al_n], al_o[al_n]);
    end
    alloc_chk(P, 0, ok, ga, go);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule